// File: doc/BRIEF.md
# Signed Multiply Unit with Multiplicand and Product Registers

This block forms the product of two 16-bit two's-complement numbers. One factor is loaded ahead of time into a multiplicand register, called T here, through a load strobe that captures the data bus. When the multiply strobe is raised, the second factor is taken either from the 16-bit data bus or from a 13-bit signed immediate field. The signed 32-bit result is then written into a product register, called P here, at the next clock edge.

T keeps its value across any number of multiplies. This lets a single coefficient be applied to a stream of bus samples, or a constant be applied to one held value. The P register is the only result output. It changes only on a multiply, so a consumer can read it at any later cycle.

Top module: `sgn_mul_unit`

## Requirements
- R1: An active-low reset clears both registers. While reset is held, and after it is released, `p_out` reads 0. A multiply issued before any T load yields 0.
- R2: When `t_load` is high at a clock edge, T captures `bus_op`. When `t_load` is low, T keeps its value.
- R3: When `mul_go` is high at a clock edge, P takes the signed 32-bit product of T and the selected operand. `p_out` shows the new value right after that edge.
- R4: With `imm_sel` = 1, the operand is `imm_op` read as a 13-bit two's-complement number (range -4096 to 4095), sign-extended to 16 bits. In this case `bus_op` has no effect on the product.
- R5: With `imm_sel` = 0, the operand is `bus_op` read as a 16-bit two's-complement number.
- R6: When `mul_go` is low, P keeps its value, whatever `t_load`, `imm_sel`, `bus_op` and `imm_op` do.
- R7: When `t_load` and `mul_go` are both high at the same edge, the product uses the T value held before that edge. T then takes the new bus value for later multiplies.
- R8: -32768 times -32768 gives exactly +2^30 (0x40000000). The extreme products 32767 × -32768 and -32768 × 32767 are also exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| t_load | input | 1 | Load T from `bus_op` at this edge |
| mul_go | input | 1 | Write the product into P at this edge |
| imm_sel | input | 1 | Operand select: 1 = immediate, 0 = data bus |
| bus_op | input | 16 | Data bus value, signed |
| imm_op | input | 13 | Immediate field, signed |
| p_out | output | 32 | Product register P, signed |

## Verification
The multiply is tried with all four sign combinations, with bus and immediate operands, and with both ends of the immediate range. These cases separate a correct sign extension from zero extension and from use of the wrong operand path. The extreme pairs -32768 × -32768 and 32767 × -32768 expose a product that is too narrow or treated as unsigned. A run of random operand pairs covers the general case. The remaining sequences tell P holding apart from P updating: idle cycles with busy inputs, T loads without a multiply, and a T load in the same cycle as a multiply.

// File: rtl/sgn_mul_pkg.sv
package sgn_mul_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IMM_W  = 13;
  localparam int unsigned PROD_W = 2 * DATA_W;

  // Widen a signed immediate to the data width by repeating its top bit
  function automatic logic [DATA_W-1:0] widen_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  // Signed product of two data-width words
  function automatic logic [PROD_W-1:0] smul(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction
endpackage

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

  // R2 R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/operand_sel.sv
module operand_sel
  import sgn_mul_pkg::*;
(
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] bus_op,
  input  logic [IMM_W-1:0]  imm_op,
  output logic [DATA_W-1:0] op_o
);
  logic [DATA_W-1:0] imm_wide;

  assign imm_wide = widen_imm(imm_op);
  assign op_o     = imm_sel ? imm_wide : bus_op;

  // R4
  always_comb begin
    if (imm_sel)
      imm_sext_chk: assert ((op_o[DATA_W-1:IMM_W-1] == '0) ||
                            (op_o[DATA_W-1:IMM_W-1] == '1));
  end
endmodule

// File: rtl/mul_core.sv
module mul_core
  import sgn_mul_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [PROD_W-1:0] prod
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] TOP_POS  = {2'b01, {(PROD_W-2){1'b0}}};

  assign prod = smul(a, b);

  // R8
  always_comb begin
    if (a == MOST_NEG && b == MOST_NEG)
      no_overflow_chk: assert (prod == TOP_POS);
  end
endmodule

// File: rtl/sgn_mul_unit.sv
module sgn_mul_unit
  import sgn_mul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t_load,
  input  logic              mul_go,
  input  logic              imm_sel,
  input  logic [DATA_W-1:0] bus_op,
  input  logic [IMM_W-1:0]  imm_op,
  output logic [PROD_W-1:0] p_out
);
  logic [DATA_W-1:0] t_val;
  logic [DATA_W-1:0] op_val;
  logic [PROD_W-1:0] prod_w;

  hold_reg #(.W(DATA_W)) u_treg (
    .clk(clk), .rst_n(rst_n), .load(t_load), .d(bus_op), .q(t_val)
  );

  operand_sel u_opsel (
    .imm_sel(imm_sel), .bus_op(bus_op), .imm_op(imm_op), .op_o(op_val)
  );

  mul_core u_core (
    .a(t_val), .b(op_val), .prod(prod_w)
  );

  hold_reg #(.W(PROD_W)) u_preg (
    .clk(clk), .rst_n(rst_n), .load(mul_go), .d(prod_w), .q(p_out)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (p_out == '0));

  // R7
  old_t_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_load && mul_go) |=> (p_out == $past(smul(t_val, op_val))));
endmodule

// File: tb/test_sgn_mul_unit.sv
module test_sgn_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        t_load, mul_go, imm_sel;
  logic [15:0] bus_op;
  logic [12:0] imm_op;
  logic [31:0] p_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  // bench model state
  logic [15:0] t_m = '0;
  logic [31:0] p_m = '0;

  always #10 clk = ~clk;

  sgn_mul_unit i_sgn_mul_unit (
    .clk(clk), .rst_n(rst_n), .t_load(t_load), .mul_go(mul_go),
    .imm_sel(imm_sel), .bus_op(bus_op), .imm_op(imm_op), .p_out(p_out)
  );

  function automatic int as_int16(input logic [15:0] v);
    int x = int'(v);
    if (x >= 32768) x = x - 65536;
    return x;
  endfunction

  function automatic int as_int13(input logic [12:0] v);
    int x = int'(v);
    if (x >= 4096) x = x - 8192;
    return x;
  endfunction

  function automatic logic [31:0] model_prod(input logic [15:0] t, input int op);
    longint r = longint'(as_int16(t)) * longint'(op);
    return r[31:0];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: p_out=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle, update model, push expected P
  task automatic step(input bit tl, input bit mg, input bit is,
                      input logic [15:0] b, input logic [12:0] im, input string tag);
    int op;
    item_t it;
    @(negedge clk);
    t_load = tl; mul_go = mg; imm_sel = is; bus_op = b; imm_op = im;
    @(posedge clk);
    op = is ? as_int13(im) : as_int16(b);
    if (mg) p_m = model_prod(t_m, op);
    if (tl) t_m = b;
    it.exp = p_m;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(p_out, it.exp, it.tag);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected=<50000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; t_load = 0; mul_go = 0; imm_sel = 0; bus_op = '0; imm_op = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(p_out, 32'h0, "R1 reset value");
    rst_n = 1'b1;
    // R1: T is zero after reset
    step(0, 1, 0, 16'd1234, 13'd0, "R1 T cleared");
    // R3 R5: bus operand, sign combinations
    step(1, 0, 0, 16'd3, 13'd0, "R6 load only");
    step(0, 1, 0, 16'd5, 13'd0, "R3 R5 3*5");
    step(1, 0, 0, 16'hFFF9, 13'd0, "R6 load -7");
    step(0, 1, 0, 16'd100, 13'd0, "R5 -7*100");
    step(1, 0, 0, -16'sd300, 13'd0, "R6 load -300");
    step(0, 1, 0, -16'sd400, 13'd0, "R5 -300*-400");
    step(0, 1, 0, 16'd1000, 13'd0, "R2 T held -300*1000");
    // R4: immediate range ends, bus distractor
    step(1, 0, 0, 16'd2, 13'd0, "R6 load 2");
    step(0, 1, 1, 16'h7FFF, 13'h0FFF, "R4 2*4095");
    step(1, 0, 0, 16'd3, 13'd0, "R6 load 3");
    step(0, 1, 1, 16'h1234, 13'h1000, "R4 3*-4096");
    step(1, 0, 0, 16'd5, 13'd0, "R6 load 5");
    step(0, 1, 1, 16'h7FFF, 13'h1FFF, "R4 5*-1");
    // R6: idle with busy inputs
    step(0, 0, 1, 16'hAAAA, 13'h0555, "R6 idle imm");
    step(0, 0, 0, 16'h5555, 13'h1AAA, "R6 idle bus");
    step(1, 0, 0, 16'd9, 13'd0, "R6 T load no mul");
    step(0, 1, 1, 16'd0, 13'd7, "R2 9*7");
    // R7: load and multiply together
    step(1, 1, 0, 16'd11, 13'd0, "R7 old T 9*11");
    step(0, 1, 0, 16'd4, 13'd0, "R7 new T 11*4");
    step(1, 1, 1, 16'hFFFF, 13'd2, "R7 imm 11*2");
    step(0, 1, 0, 16'd6, 13'd0, "R7 new T -1*6");
    // R8: extremes
    step(1, 0, 0, 16'h8000, 13'd0, "R6 load min");
    step(0, 1, 0, 16'h8000, 13'd0, "R8 min*min");
    step(0, 1, 0, 16'h7FFF, 13'd0, "R8 min*max");
    step(1, 0, 0, 16'h7FFF, 13'd0, "R6 load max");
    step(0, 1, 0, 16'h8000, 13'd0, "R8 max*min");
    // random mix
    for (int k = 0; k < 40; k++) begin
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), 16'($urandom), 13'($urandom), "R3 random");
    end
    // directed value checks against the model's computed constants
    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    begin
      logic [31:0] e8 = 32'h40000000;
      check(model_prod(16'h8000, -32768), e8, "R8 bench model 2^30");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule